// File: doc/BRIEF.md
# Battery-Backed SRAM Power-Fail Controller

This block is a clocked model of a byte-wide static RAM whose accesses are governed by a supply supervisor. The array takes active-low chip-select, write-strobe and output-enable controls. Reads are registered, writes are committed on the clock in which the write ends, and the data drivers are shown as an enable plus a data bus that is forced to zero while not driven.

The supply level is given as three comparator flags: above the trip point, above the full-operation threshold (4.5 V), and above the switchover threshold (3.0 V). A four-state supervisor decides when access is allowed, when the array is write-protected with its outputs off, and when it runs from the backup cell. Normal access returns only above the full-operation level. After reset the supervisor is in a ship state where the backup cell is disconnected. It arms the backup the first time the trip flag is seen. If the supply is lost before that, the contents are reported invalid.

The full-size array uses `ADDR_W` = 13 (8192 bytes). The default is smaller so that the default elaboration stays small.

Top module: `nvsram_guard`

## Requirements
- R1: The array holds 2**ADDR_W bytes of DATA_W bits (ADDR_W = 13 gives 8192 bytes). A byte written to an address reads back unchanged at that address.
- R2: `rdata_oe_o` is high, in the same cycle as its inputs, exactly when access is allowed, `ce_n_i` = 0, `we_n_i` = 1 and `oe_n_i` = 0. `rdata_o` carries the byte at the address sampled on the previous clock while `ce_n_i` was 0, and is zero whenever `rdata_oe_o` is low.
- R3: A write is in progress while `ce_n_i` and `we_n_i` are both 0. It starts at the later of the two falling, and it is committed on the clock where the first of them is seen high. The address and data used are those sampled on the last clock of the overlap.
- R4: When `we_n_i` falls while the outputs are driven, `rdata_oe_o` drops in that same cycle.
- R5: A write may start only after `we_n_i` has been sampled high on REC_CYC clocks since the previous write ended (a counter reset at each write end and saturating at REC_CYC). A write that starts too early is ignored for its whole overlap, and `wr_err_o` pulses high for one cycle after the clock at which it started.
- R6: When the trip flag is low, the block leaves the run state on the next clock. Outside the run state, `access_ok_o` is 0, `rdata_oe_o` is 0, no write starts, and a write already in progress is aborted without changing the array.
- R7: In the protected state with the 3.0 V flag low, the block switches to the backup cell (`on_backup_o` = 1) on the next clock. When the 3.0 V flag returns high, it goes back to the protected state on the main supply. The array contents are retained across this.
- R8: From the protected state, the run state (`access_ok_o` = 1) is entered only on a clock where the 4.5 V flag is high. The trip flag alone is not enough.
- R9: After reset the block is in the ship state: `backup_armed_o` = 0, `access_ok_o` = 0, and the backup is never connected. The first clock with the trip flag high moves the block to the protected state and sets `backup_armed_o`, which stays set until reset.
- R10: In the ship state, a clock with the 3.0 V flag low clears `data_valid_o`. It stays cleared until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sup_trip_i | input | 1 | Supply above the write-protect trip point |
| sup_hi_i | input | 1 | Supply above the full-operation level (4.5 V) |
| sup_lo_i | input | 1 | Supply above the backup switchover level (3.0 V) |
| ce_n_i | input | 1 | Chip select, active low |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, zero when not driven |
| rdata_oe_o | output | 1 | Data drivers enabled |
| wr_err_o | output | 1 | One-cycle pulse on a write that violated the recovery time |
| access_ok_o | output | 1 | Run state: accesses allowed |
| on_backup_o | output | 1 | Array powered from the backup cell |
| backup_armed_o | output | 1 | Backup cell connected for retention (ship state left) |
| data_valid_o | output | 1 | Array contents trustworthy |

## Verification
The bench builds the block with ADDR_W = 6 and REC_CYC = 3. The small array lets the reference model track every byte and whether it is known. The short recovery window lets the bench start a write one idle cycle after the previous one ends, which is too early, and then retry it once the window has elapsed. Under these values the bench walks through every supervisor path in a few hundred cycles:
- aborting a write when the trip flag drops,
- dropping to the backup cell and coming back,
- losing the supply in the ship state after a second reset.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    PS_SHIP    = 2'd0,
    PS_GUARD   = 2'd1,
    PS_BACKUP  = 2'd2,
    PS_RUN     = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/nvs_supply_fsm.sv
module nvs_supply_fsm
  import nvs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sup_trip_i,
  input  logic sup_hi_i,
  input  logic sup_lo_i,
  output logic acc_ok_o,
  output logic on_backup_o,
  output logic armed_o,
  output logic valid_o
);
  pwr_state_e state_q, state_d;
  logic       valid_q, valid_d;

  always_comb begin
    state_d = state_q;
    valid_d = valid_q;
    case (state_q)
      PS_SHIP: begin
        if (sup_trip_i)     state_d = PS_GUARD;
        else if (!sup_lo_i) valid_d = 1'b0;
      end
      PS_GUARD: begin
        if (!sup_lo_i)     state_d = PS_BACKUP;
        else if (sup_hi_i) state_d = PS_RUN;
      end
      PS_RUN: begin
        if (!sup_trip_i) state_d = PS_GUARD;
      end
      PS_BACKUP: begin
        if (sup_lo_i) state_d = PS_GUARD;
      end
      default: state_d = PS_SHIP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_SHIP;
      valid_q <= 1'b1;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
    end
  end

  assign acc_ok_o    = (state_q == PS_RUN);
  assign on_backup_o = (state_q == PS_BACKUP);
  assign armed_o     = (state_q != PS_SHIP);
  assign valid_o     = valid_q;

  AST_RESUME_NEEDS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_ok_o) |-> $past(sup_hi_i)); // R8
  AST_BACKUP_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_backup_o) |-> $past(armed_o)); // R9
  AST_INVALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |=> !valid_o); // R10
endmodule

// File: rtl/nvs_wr_ctrl.sv
module nvs_wr_ctrl #(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter int REC_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_ok_i,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              wr_err_o
);
  localparam int CNT_W = $clog2(REC_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(REC_CYC);

  logic              act_q, act_d;
  logic              blk_q, blk_d;
  logic              err_q, err_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] la_q;
  logic [DATA_W-1:0] ld_q;
  logic              overlap, start, early, wr_end, commit, lat_en;

  always_comb begin
    overlap = !ce_n_i && !we_n_i;
    start   = acc_ok_i && overlap && !act_q && !blk_q;
    early   = start && (cnt_q < CNT_MAX);
    wr_end  = act_q && (!acc_ok_i || !overlap);
    commit  = act_q && acc_ok_i && !overlap;
    lat_en  = (start && !early) || (act_q && acc_ok_i && overlap);
    act_d   = (act_q && !wr_end) || (start && !early);
    blk_d   = overlap && (blk_q || early);
    err_d   = early;
    if (wr_end)                      cnt_d = '0;
    else if (we_n_i && cnt_q < CNT_MAX) cnt_d = cnt_q + 1'b1;
    else                             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      blk_q <= 1'b0;
      err_q <= 1'b0;
      cnt_q <= CNT_MAX;
    end else begin
      act_q <= act_d;
      blk_q <= blk_d;
      err_q <= err_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lat_en) begin
      la_q <= addr_i;
      ld_q <= wdata_i;
    end
  end

  assign mem_we_o    = commit;
  assign mem_addr_o  = la_q;
  assign mem_wdata_o = ld_q;
  assign wr_err_o    = err_q;

  AST_COMMIT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> acc_ok_i); // R6
  AST_COMMIT_AFTER_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(!ce_n_i && !we_n_i)); // R3
  AST_ERR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err_o |=> !wr_err_o); // R5
endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (re_i) rd_q <= mem[raddr_i];
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/nvsram_guard.sv
module nvsram_guard #(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter int REC_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sup_trip_i,
  input  logic              sup_hi_i,
  input  logic              sup_lo_i,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              wr_err_o,
  output logic              access_ok_o,
  output logic              on_backup_o,
  output logic              backup_armed_o,
  output logic              data_valid_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              acc_ok;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] arr_rdata;
  logic              drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  nvs_supply_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sup_trip_i  (sup_trip_i),
    .sup_hi_i    (sup_hi_i),
    .sup_lo_i    (sup_lo_i),
    .acc_ok_o    (acc_ok),
    .on_backup_o (on_backup_o),
    .armed_o     (backup_armed_o),
    .valid_o     (data_valid_o)
  );

  nvs_wr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REC_CYC(REC_CYC)) u_wr (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .acc_ok_i    (acc_ok),
    .ce_n_i      (ce_n_i),
    .we_n_i      (we_n_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .wr_err_o    (wr_err_o)
  );

  nvs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk     (clk),
    .we_i    (mem_we),
    .waddr_i (mem_addr),
    .wdata_i (mem_wdata),
    .re_i    (acc_ok && !ce_n_i),
    .raddr_i (addr_i),
    .rdata_o (arr_rdata)
  );

  assign drive       = acc_ok && !ce_n_i && we_n_i && !oe_n_i;
  assign rdata_oe_o  = drive;
  assign rdata_o     = drive ? arr_rdata : '0;
  assign access_ok_o = acc_ok;

  AST_BACKUP_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    on_backup_o |-> !rdata_oe_o); // R6
endmodule

// File: tb/nvsram_guard_test.sv
module nvsram_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 6;
  localparam int DW  = 8;
  localparam int REC = 3;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip = 1'b0, hi = 1'b0, lo = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe, wr_err, access_ok, on_backup, armed, dvalid;

  int checks = 0;
  int fails  = 0;
  bit model_on = 1'b0;

  // reference model state
  int m_st;      // 0 ship, 1 guard, 2 backup, 3 run
  bit m_valid, m_act, m_blk, m_err, m_rdk;
  int m_cnt;
  logic [AW-1:0] m_la;
  logic [DW-1:0] m_ld, m_rdq;
  logic [DW-1:0] m_mem [64];
  bit m_known [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  nvsram_guard #(.ADDR_W(AW), .DATA_W(DW), .REC_CYC(REC)) uut (
    .clk(clk), .rst_n(rst_n), .sup_trip_i(trip), .sup_hi_i(hi), .sup_lo_i(lo),
    .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rdata_oe_o(rdata_oe), .wr_err_o(wr_err),
    .access_ok_o(access_ok), .on_backup_o(on_backup),
    .backup_armed_o(armed), .data_valid_o(dvalid)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_valid = 1; m_act = 0; m_blk = 0; m_err = 0; m_cnt = REC; m_rdk = 0;
  endtask

  task automatic model_edge();
    bit ok, ov, start, early, wend, commit, latch;
    ok     = (m_st == 3);
    ov     = !ce_n && !we_n;
    start  = ok && ov && !m_act && !m_blk;
    early  = start && (m_cnt < REC);
    wend   = m_act && (!ok || !ov);
    commit = m_act && ok && !ov;
    latch  = (start && !early) || (m_act && ok && ov);
    if (ok && !ce_n) begin m_rdq = m_mem[addr]; m_rdk = m_known[addr]; end
    if (commit) begin m_mem[m_la] = m_ld; m_known[m_la] = 1; end
    if (latch) begin m_la = addr; m_ld = wdata; end
    if (wend) m_cnt = 0;
    else if (we_n && m_cnt < REC) m_cnt = m_cnt + 1;
    m_act = (m_act && !wend) || (start && !early);
    m_blk = ov && (m_blk || early);
    m_err = early;
    case (m_st)
      0: if (trip) m_st = 1; else if (!lo) m_valid = 0;
      1: if (!lo) m_st = 2; else if (hi) m_st = 3;
      3: if (!trip) m_st = 1;
      default: if (lo) m_st = 1;
    endcase
  endtask

  task automatic compare_all();
    bit exp_oe;
    exp_oe = (m_st == 3) && !ce_n && we_n && !oe_n;
    chk(access_ok, m_st == 3, "R8 access_ok");
    chk(on_backup, m_st == 2, "R7 on_backup");
    chk(armed, m_st != 0, "R9 armed");
    chk(dvalid, m_valid, "R10 data_valid");
    chk(wr_err, m_err, "R5 wr_err");
    chk(rdata_oe, exp_oe, "R2 rdata_oe");
    if (!exp_oe) chk(rdata, 0, "R2 rdata idle");
    else if (m_rdk) chk(rdata, m_rdq, "R1 rdata");
  endtask

  task automatic step();
    @(posedge clk);
    if (model_on) model_edge();
    #1;
    if (model_on) compare_all();
  endtask

  task automatic cyc(input logic c, input logic w, input logic o,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ce_n = c; we_n = w; oe_n = o; addr = a; wdata = d;
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 1, addr, wdata);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(0, 0, 1, a, d);
    cyc(0, 0, 1, a, d);
    cyc(1, 1, 1, a, d);
    idle(REC);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    cyc(0, 1, 1, a, 0);
    cyc(0, 1, 0, a, 0);
    chk(rdata_oe, 1, tag);
    chk(rdata, e, tag);
    idle(1);
  endtask

  task automatic set_sup(input logic t, input logic h, input logic l);
    @(negedge clk);
    trip = t; hi = h; lo = l;
    step();
  endtask

  task automatic do_reset();
    model_on = 0;
    @(negedge clk);
    rst_n = 0; trip = 0; hi = 0; lo = 1;
    ce_n = 1; we_n = 1; oe_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    model_reset();
    model_on = 1;
    #1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_known[i] = 0;
    do_reset();
    // R9: ship state after reset
    chk(armed, 0, "R9 reset armed");
    chk(access_ok, 0, "R9 reset access");
    chk(dvalid, 1, "R10 reset valid");
    chk(rdata_oe, 0, "R2 reset drive");

    // R9/R8: trip arms, access needs hi
    set_sup(1, 0, 1);
    chk(armed, 1, "R9 armed on trip");
    idle(2);
    chk(access_ok, 0, "R8 no access without hi");
    set_sup(1, 1, 1);
    chk(access_ok, 1, "R8 access with hi");
    idle(REC);

    // R1/R3: WE-controlled writes and readback
    wr(5, 8'hA5);
    wr(6, 8'h3C);
    rd_chk(5, 8'hA5, "R1 R3 readback 5");
    rd_chk(6, 8'h3C, "R1 readback 6");
    idle(REC);

    // R2: output enable high keeps drivers off
    cyc(0, 1, 1, 5, 0);
    chk(rdata_oe, 0, "R2 oe_n high");
    chk(rdata, 0, "R2 rdata zero");

    // R4: WE falling while driving turns drivers off this cycle
    cyc(0, 1, 0, 6, 8'h3C);
    chk(rdata_oe, 1, "R4 driving");
    cyc(0, 0, 0, 6, 8'h3C);
    chk(rdata_oe, 0, "R4 we fall drops drive");
    cyc(1, 1, 1, 6, 8'h3C);
    idle(REC);

    // R5: too-early write rejected with one pulse
    wr(7, 8'h11);
    idle(REC);
    cyc(0, 0, 1, 7, 8'h11);
    cyc(0, 0, 1, 7, 8'h11);
    cyc(1, 1, 1, 7, 8'h11);
    cyc(1, 1, 1, 7, 8'h11);
    cyc(0, 0, 1, 7, 8'h22);
    chk(wr_err, 1, "R5 early error pulse");
    cyc(0, 0, 1, 7, 8'h22);
    chk(wr_err, 0, "R5 pulse one cycle");
    cyc(1, 1, 1, 7, 8'h22);
    idle(REC);
    rd_chk(7, 8'h11, "R5 rejected write ignored");
    idle(REC);

    // R3: CE-controlled write (WE low first)
    cyc(1, 0, 1, 9, 8'h5A);
    cyc(0, 0, 1, 9, 8'h5A);
    cyc(0, 0, 1, 9, 8'h5A);
    cyc(1, 0, 1, 9, 8'h5A);
    idle(REC + 1);
    rd_chk(9, 8'h5A, "R3 ce-controlled write");
    idle(REC);

    // R6: write aborted by trip drop
    wr(12, 8'h55);
    cyc(0, 0, 1, 12, 8'h77);
    @(negedge clk); trip = 0; hi = 0; ce_n = 0; we_n = 0; step();
    chk(access_ok, 0, "R6 protected");
    cyc(0, 0, 1, 12, 8'h77);
    cyc(1, 1, 1, 12, 8'h77);
    cyc(0, 1, 0, 12, 8'h00);
    chk(rdata_oe, 0, "R6 no drive when protected");
    cyc(0, 0, 1, 12, 8'h99);
    cyc(1, 1, 1, 12, 8'h99);
    set_sup(1, 0, 1);
    chk(access_ok, 0, "R8 trip alone not enough");
    set_sup(1, 1, 1);
    idle(REC);
    rd_chk(12, 8'h55, "R6 aborted write left array");
    idle(REC);

    // R7: backup and back
    set_sup(0, 0, 0);
    set_sup(0, 0, 0);
    chk(on_backup, 1, "R7 on backup");
    cyc(0, 1, 0, 5, 0);
    chk(rdata_oe, 0, "R6 outputs off on backup");
    set_sup(0, 0, 1);
    chk(on_backup, 0, "R7 back on main");
    set_sup(1, 1, 1);
    idle(REC);
    rd_chk(5, 8'hA5, "R7 data retained");

    // R9/R10: supply lost in ship state
    do_reset();
    set_sup(0, 0, 0);
    chk(dvalid, 0, "R10 ship loss invalid");
    chk(on_backup, 0, "R9 no backup in ship");
    set_sup(0, 0, 1);
    set_sup(1, 1, 1);
    idle(2);
    chk(dvalid, 0, "R10 invalid sticky");
    chk(armed, 1, "R9 armed later");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule